// File: doc/BRIEF.md
# Serial Divider Program Loader

This block is the programming front end of a frequency synthesizer. A host shifts a 32-bit word into it one bit at a time, using a slow serial clock and a data line. When the host raises the load enable, the block moves the shifted fields into holding registers. These registers drive the reference-divider value and the two loop-divider values (A and N), which go to the divider logic.

The bit that arrives last is a control flag, and it decides whether the reference value is taken. The A and N values are taken on every load, whatever the flag holds. While the load enable stays high, the holding registers follow the shift chain. While it is low, they keep their contents, so the host can shift in the next word without disturbing the dividers.

The block has its own system clock. The serial clock, serial data and load enable are each brought in through a multi-stage synchronizer. Shift-clock rising edges are detected in the system clock domain.

Top module: `synth_div_loader`

## Requirements
- R1: While the active-low reset is asserted, the reference, A and N outputs read zero. They stay zero until a load takes place after reset is released.
- R2: On each low-to-high transition of the serial clock, the data line is shifted into the chain. The word is sent most significant bit first, in this order: 14-bit reference field, 7-bit A field, 10-bit N field, then the 1-bit control flag. After 32 shifts, each field lands in its own output position.
- R3: When the load enable is high and the control flag is 1, the reference output takes the shifted reference field.
- R4: When the load enable is high and the control flag is 0, the reference output keeps its previous value.
- R5: When the load enable is high, the A and N outputs take the shifted A and N fields. This holds whether the control flag is 0 or 1.
- R6: While the load enable is low, shifting new words in leaves all three outputs unchanged.
- R7: While the load enable is held high, the outputs are transparent. Bits shifted in during that time appear at the outputs without a new enable edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, sampled on serial clock rise |
| load_en_i | input | 1 | Level-sensitive load enable |
| ref_div_o | output | 14 | Held reference-divider value |
| a_div_o | output | 7 | Held A-divider value |
| n_div_o | output | 10 | Held N-divider value |

## Verification
The assertions assume that the serial clock, serial data and load enable each hold a level for several system clocks. They also assume that the data line does not move in the same system cycle as a serial clock rise. Without these conditions, the synchronized copies could disagree about which bit a shift edge captured. The bench meets these assumptions by driving every input on the falling system edge. It holds each level for four system clocks, and it changes data only while the serial clock is low. The bench samples outputs only after the synchronizer and register latency has fully elapsed.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
   // Minimum synchronizer depth accepted for asynchronous inputs
   localparam int unsigned SDL_MIN_SYNC = 2;

   // Total serial chain length: control flag plus all fields
   function automatic int unsigned sdl_chain_len(input int unsigned ref_w,
                                                 input int unsigned a_w,
                                                 input int unsigned n_w);
      return ref_w + a_w + n_w + 1;
   endfunction

   // Index of the synchronized bus bits
   typedef enum int unsigned {
      SDL_SYN_SCLK = 0,
      SDL_SYN_DAT  = 1,
      SDL_SYN_EN   = 2
   } sdl_syn_idx_e;

   localparam int unsigned SDL_SYN_W = 3;
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sdl_shift_chain.sv
module sdl_shift_chain #(
   parameter int unsigned CHAIN_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               dat_s,
   output logic               shift_p,
   output logic [CHAIN_W-1:0] chain
);
   logic sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end

   assign shift_p = sclk_s & ~sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       chain <= '0;
      else if (shift_p) chain <= {chain[CHAIN_W-2:0], dat_s};
   end
endmodule

// File: rtl/sdl_hold_latch.sv
module sdl_hold_latch #(
   parameter int unsigned W     = 8,
   parameter bit          GATED = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         gate,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic take;

   if (GATED) begin : g_gated
      assign take = en & gate;
   end else begin : g_plain
      logic unused_gate;
      assign unused_gate = gate;
      assign take = en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (take) q <= d;
   end
endmodule

// File: rtl/synth_div_loader.sv
module synth_div_loader #(
   parameter int unsigned REF_W       = 14,
   parameter int unsigned A_W         = 7,
   parameter int unsigned N_W         = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk_i,
   input  logic             ser_dat_i,
   input  logic             load_en_i,
   output logic [REF_W-1:0] ref_div_o,
   output logic [A_W-1:0]   a_div_o,
   output logic [N_W-1:0]   n_div_o
);
   import sdl_pkg::*;

   localparam int unsigned AN_W    = A_W + N_W;
   localparam int unsigned CHAIN_W = sdl_chain_len(REF_W, A_W, N_W);
   localparam int unsigned REF_LSB = AN_W + 1;

   if (SYNC_STAGES < SDL_MIN_SYNC) begin : g_bad_sync
      $error("synth_div_loader: SYNC_STAGES below minimum");
   end
   if (REF_W < 1 || A_W < 1 || N_W < 1) begin : g_bad_width
      $error("synth_div_loader: field widths must be nonzero");
   end

   logic [SDL_SYN_W-1:0] raw_bus;
   logic [SDL_SYN_W-1:0] syn_bus;
   logic                 dat_s;
   logic                 en_s;
   logic                 sclk_s;
   logic                 shift_p;
   logic [CHAIN_W-1:0]   chain;
   logic [AN_W-1:0]      an_q;

   assign raw_bus[SDL_SYN_SCLK] = ser_clk_i;
   assign raw_bus[SDL_SYN_DAT]  = ser_dat_i;
   assign raw_bus[SDL_SYN_EN]   = load_en_i;

   sdl_sync #(.STAGES(SYNC_STAGES), .W(SDL_SYN_W)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_bus),
      .q     (syn_bus)
   );

   assign sclk_s = syn_bus[SDL_SYN_SCLK];
   assign dat_s  = syn_bus[SDL_SYN_DAT];
   assign en_s   = syn_bus[SDL_SYN_EN];

   sdl_shift_chain #(.CHAIN_W(CHAIN_W)) shift_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (sclk_s),
      .dat_s   (dat_s),
      .shift_p (shift_p),
      .chain   (chain)
   );

   sdl_hold_latch #(.W(REF_W), .GATED(1'b1)) ref_latch_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_s),
      .gate  (chain[0]),
      .d     (chain[REF_LSB +: REF_W]),
      .q     (ref_div_o)
   );

   sdl_hold_latch #(.W(AN_W), .GATED(1'b0)) an_latch_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_s),
      .gate  (chain[0]),
      .d     (chain[1 +: AN_W]),
      .q     (an_q)
   );

   assign a_div_o = an_q[N_W +: A_W];
   assign n_div_o = an_q[0 +: N_W];
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker #(
   parameter int unsigned CHAIN_W = 32,
   parameter int unsigned REF_W   = 14,
   parameter int unsigned AN_W    = 17
) (
   input logic               clk,
   input logic               rst_n,
   input logic               shift_p,
   input logic               dat_s,
   input logic               en_s,
   input logic [CHAIN_W-1:0] chain,
   input logic [REF_W-1:0]   ref_o,
   input logic [AN_W-1:0]    an_o
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (ref_o == '0 && an_o == '0));

   assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_p |=> chain == {$past(chain[CHAIN_W-2:0]), $past(dat_s)});

   assert_shift_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_p |=> $stable(chain));

   assert_ref_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_s && chain[0]) |=> ref_o == $past(chain[CHAIN_W-1 -: REF_W]));

   assert_ref_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_s && !chain[0]) |=> $stable(ref_o));

   assert_an_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      en_s |=> an_o == $past(chain[AN_W:1]));

   assert_hold_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> ($stable(ref_o) && $stable(an_o)));
endmodule

bind synth_div_loader sdl_checker #(
   .CHAIN_W (CHAIN_W),
   .REF_W   (REF_W),
   .AN_W    (AN_W)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .shift_p (shift_p),
   .dat_s   (dat_s),
   .en_s    (en_s),
   .chain   (chain),
   .ref_o   (ref_div_o),
   .an_o    ({a_div_o, n_div_o})
);

// File: tb/synth_div_loader_tb_top.sv
`timescale 1ns/1ps
module synth_div_loader_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       sdat = 1'b0;
   logic       len  = 1'b0;
   logic [13:0] ref_o;
   logic [6:0]  a_o;
   logic [9:0]  n_o;
   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   synth_div_loader dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_clk_i (sclk),
      .ser_dat_i (sdat),
      .load_en_i (len),
      .ref_div_o (ref_o),
      .a_div_o   (a_o),
      .n_div_o   (n_o)
   );

   // {ctrl, ref, a, n, expected ref after the load}
   localparam logic [45:0] VEC [5] = '{
      {1'b1, 14'h1ABC, 7'h55, 10'h2F3, 14'h1ABC},
      {1'b0, 14'h0123, 7'h0A, 10'h155, 14'h1ABC},
      {1'b1, 14'h3FFF, 7'h7F, 10'h3FF, 14'h3FFF},
      {1'b0, 14'h2AAA, 7'h00, 10'h000, 14'h3FFF},
      {1'b1, 14'h0000, 7'h01, 10'h200, 14'h0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bit(input logic b);
      sdat = b;
      idle(4);
      sclk = 1'b1;
      idle(4);
      sclk = 1'b0;
      idle(4);
   endtask

   task automatic shift_word(input logic [13:0] r, input logic [6:0] a,
                             input logic [9:0] n, input logic c);
      logic [31:0] w;
      w = {r, a, n, c};
      for (int i = 31; i >= 0; i--) shift_bit(w[i]);
   endtask

   task automatic pulse_load();
      len = 1'b1;
      idle(6);
      len = 1'b0;
      idle(6);
   endtask

   initial begin
      idle(5);
      chk("R1 ref reset", {18'd0, ref_o}, 32'd0);
      chk("R1 a reset",   {25'd0, a_o},   32'd0);
      chk("R1 n reset",   {22'd0, n_o},   32'd0);
      rst_n = 1'b1;
      idle(4);

      for (int k = 0; k < 5; k++) begin
         shift_word(VEC[k][44:31], VEC[k][30:24], VEC[k][23:14], VEC[k][45]);
         pulse_load();
         chk(VEC[k][45] ? "R3 ref load" : "R4 ref kept", {18'd0, ref_o}, {18'd0, VEC[k][13:0]});
         chk("R5 R2 a load", {25'd0, a_o}, {25'd0, VEC[k][30:24]});
         chk("R5 R2 n load", {22'd0, n_o}, {22'd0, VEC[k][23:14]});
      end

      // R7: enable held high, new word flows through
      len = 1'b1;
      idle(6);
      shift_word(14'h0F0F, 7'h33, 10'h0CC, 1'b1);
      idle(6);
      chk("R7 ref transparent", {18'd0, ref_o}, 32'h0F0F);
      chk("R7 a transparent",   {25'd0, a_o},   32'h33);
      chk("R7 n transparent",   {22'd0, n_o},   32'h0CC);
      len = 1'b0;
      idle(6);

      // R6: shifting with enable low changes nothing
      shift_word(14'h3333, 7'h7E, 10'h111, 1'b1);
      idle(6);
      chk("R6 ref held", {18'd0, ref_o}, 32'h0F0F);
      chk("R6 a held",   {25'd0, a_o},   32'h33);
      chk("R6 n held",   {22'd0, n_o},   32'h0CC);

      // R1: reset in service clears outputs
      rst_n = 1'b0;
      idle(2);
      chk("R1 ref cleared", {18'd0, ref_o}, 32'd0);
      chk("R1 a cleared",   {25'd0, a_o},   32'd0);
      chk("R1 n cleared",   {22'd0, n_o},   32'd0);

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule